// File: doc/BRIEF.md
# Nonlinear Carry-Select Adder

This block adds two 64-bit operands and a carry-in. It produces a 64-bit sum and a carry-out in a single combinational pass. The operand word is cut into nine slices, and each slice is wider than the one below it. The lowest slice is a single ripple-carry chain fed by the external carry-in.

Every higher slice holds two ripple chains that run in parallel. One assumes an incoming carry of zero and the other assumes an incoming carry of one. When the real carry arrives from the slice below, it only steers a multiplexer, so the worst path is the bottom slice's ripple plus one select per slice above it. The slices widen up the word because higher slices get their carry later and so have more time to ripple.

A parameter rebuilds the same structure with equal-width slices, so both layouts can be compared on the same ports.

Top module: `nlcs_adder`

## Requirements
- R1: `sum` and `cout` together equal the 65-bit value `op_a + op_b + cin`, with `cout` as bit 64.
- R2: In the default layout the slices, from bit 0 upward, are 4, 4, 5, 6, 7, 8, 9, 10 and 11 bits wide. The slice boundaries therefore sit at bits 4, 8, 13, 19, 26, 34, 43 and 53.
- R3: Every slice above the lowest forms two candidate results. The carry-in-one candidate (its carry and sum taken together) always equals the carry-in-zero candidate plus one.
- R4: A slice's carry-out is its carry-in-zero carry, OR the incoming carry AND its carry-in-one carry. A zero-assumption carry never occurs without the one-assumption carry.
- R5: The lowest slice is one ripple chain driven directly by `cin`. Each of its bits forms its carry as generate OR (propagate AND incoming carry).
- R6: A carry that enters any slice boundary lands on that boundary bit. This holds whether the carry comes from a run of ones below the boundary plus 1, from `cin` running through ones, or from a generate in the top bit of the lower slice.
- R7: A full-width propagate (all-ones plus zero with `cin` = 1) gives `sum` = 0 and `cout` = 1. All-ones plus all-ones with `cin` = 1 gives all-ones with `cout` = 1.
- R8: With `LINEAR` = 1 (eight equal 8-bit slices), the block gives the same `sum` and `cout` as the default layout for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 64 | Sum bits |
| cout | output | 1 | Carry out of bit 63 |

## Verification
The block holds no state, so every result is due in the same cycle as the operands that produce it, after the carry chain settles. The bench drives a new operand set just after a rising clock edge and reads `sum` and `cout` at the following falling edge, half a period later. No register sits between input and output, so no extra cycle is ever counted. The default and equal-width instances are read at the same instant against one reference sum.

// File: rtl/nlcs_pkg.sv
package nlcs_pkg;

  localparam int ADD_W = 64;
  localparam int NL_SECTIONS = 9;

  function automatic int sec_count(input bit lin, input int lin_w);
    return lin ? (ADD_W / lin_w) : NL_SECTIONS;
  endfunction

  // slice widths grow by one from the third slice upward
  function automatic int sec_width(input bit lin, input int lin_w, input int k);
    if (lin) return lin_w;
    if (k < 2) return 4;
    return k + 3;
  endfunction

  function automatic int sec_base(input bit lin, input int lin_w, input int k);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += sec_width(lin, lin_w, j);
    return acc;
  endfunction

endpackage

// File: rtl/nlcs_ripple.sv
module nlcs_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W:0]   chain;
  logic [W-1:0] prop;
  logic [W-1:0] gen;

  assign prop = x ^ y;
  assign gen  = x & y;

  always_comb begin
    chain[0] = ci;
    for (int i = 0; i < W; i++) begin
      chain[i+1] = gen[i] | (prop[i] & chain[i]);
    end
  end

  assign s  = prop ^ chain[W-1:0];
  assign co = chain[W];

  always_comb begin
    AST_RIPPLE_EXACT: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci})); // R5
  end

endmodule

// File: rtl/nlcs_select_sec.sv
module nlcs_select_sec #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W-1:0] s_z;
  logic [W-1:0] s_o;
  logic         c_z;
  logic         c_o;

  nlcs_ripple #(.W(W)) u_rip_zero (
    .x(x), .y(y), .ci(1'b0), .s(s_z), .co(c_z)
  );

  nlcs_ripple #(.W(W)) u_rip_one (
    .x(x), .y(y), .ci(1'b1), .s(s_o), .co(c_o)
  );

  assign s  = ci ? s_o : s_z;
  assign co = c_z | (ci & c_o);

  always_comb begin
    AST_CAND_PLUS_ONE: assert ({c_o, s_o} == ({c_z, s_z} + {{W{1'b0}}, 1'b1})); // R3
    AST_CARRY_ORDER: assert (!c_z || c_o); // R4
  end

endmodule

// File: rtl/nlcs_adder.sv
module nlcs_adder #(
  parameter bit LINEAR    = 1'b0,
  parameter int LIN_SEC_W = 8
) (
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic        cin,
  output logic [63:0] sum,
  output logic        cout
);

  import nlcs_pkg::*;

  localparam int NSEC = sec_count(LINEAR, LIN_SEC_W);

  logic [NSEC:0] sec_c;

  assign sec_c[0] = cin;

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    localparam int SW = sec_width(LINEAR, LIN_SEC_W, k);
    localparam int SB = sec_base(LINEAR, LIN_SEC_W, k);
    if (k == 0) begin : g_first
      nlcs_ripple #(.W(SW)) u_first (
        .x (op_a[SB +: SW]),
        .y (op_b[SB +: SW]),
        .ci(sec_c[k]),
        .s (sum[SB +: SW]),
        .co(sec_c[k+1])
      );
    end else begin : g_upper
      nlcs_select_sec #(.W(SW)) u_sel (
        .x (op_a[SB +: SW]),
        .y (op_b[SB +: SW]),
        .ci(sec_c[k]),
        .s (sum[SB +: SW]),
        .co(sec_c[k+1])
      );
    end
  end

  assign cout = sec_c[NSEC];

  always_comb begin
    AST_FULL_SUM: assert ({cout, sum} == ({1'b0, op_a} + {1'b0, op_b} + {64'd0, cin})); // R1
  end

endmodule

// File: tb/tb_nlcs_adder.sv
module tb_nlcs_adder;

  logic        clk;
  logic        rst_n;
  logic [63:0] op_a;
  logic [63:0] op_b;
  logic        cin;
  logic [63:0] sum;
  logic        cout;
  logic [63:0] sum_lin;
  logic        cout_lin;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic        c;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{64'h0, 64'h0, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},
    '{64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1},
    '{64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b0},
    '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0},
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 1'b1},
    '{64'hDEAD_BEEF_CAFE_F00D, 64'h2152_4110_3501_0FF2, 1'b1},
    '{64'h00FF_00FF_00FF_00FF, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1}
  };

  localparam int NBND = 8;
  localparam int BND [NBND] = '{4, 8, 13, 19, 26, 34, 43, 53};

  nlcs_adder dut (
    .op_a(op_a), .op_b(op_b), .cin(cin), .sum(sum), .cout(cout)
  );

  nlcs_adder #(.LINEAR(1'b1), .LIN_SEC_W(8)) dut_lin (
    .op_a(op_a), .op_b(op_b), .cin(cin), .sum(sum_lin), .cout(cout_lin)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic c);
    @(posedge clk);
    #0.5;
    op_a = a;
    op_b = b;
    cin  = c;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [64:0] got, input logic [64:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [64:0] ref_add(input logic [63:0] a, input logic [63:0] b, input logic c);
    return {1'b0, a} + {1'b0, b} + {64'd0, c};
  endfunction

  initial begin
    op_a  = '0;
    op_b  = '0;
    cin   = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset-state zero inputs", {cout, sum}, 65'd0);

    // table walk: R1 and R8
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].c);
      chk("R1 table vector", {cout, sum}, ref_add(VECS[i].a, VECS[i].b, VECS[i].c));
      chk("R8 equal-width variant", {cout_lin, sum_lin}, ref_add(VECS[i].a, VECS[i].b, VECS[i].c));
    end

    // R2/R6: carries arriving at each slice boundary
    for (int k = 0; k < NBND; k++) begin
      logic [63:0] ones;
      ones = (64'd1 << BND[k]) - 64'd1;
      apply(ones, 64'd1, 1'b0);
      chk("R6 ones-plus-one at boundary (R2)", {cout, sum}, {1'b0, 64'd1 << BND[k]});
      apply(ones, 64'd0, 1'b1);
      chk("R6 cin through ones to boundary (R5)", {cout, sum}, {1'b0, 64'd1 << BND[k]});
      apply(64'd1 << (BND[k] - 1), 64'd1 << (BND[k] - 1), 1'b0);
      chk("R6 generate at slice top (R4)", {cout, sum}, {1'b0, 64'd1 << BND[k]});
      chk("R8 boundary in equal-width variant", {cout_lin, sum_lin}, {1'b0, 64'd1 << BND[k]});
    end

    // R3: candidate selection in an upper slice, both carry values
    apply(64'h0000_0FF0_0000_0000, 64'h0000_0010_0000_0000, 1'b0);
    chk("R3 upper slice no incoming carry", {cout, sum}, ref_add(64'h0000_0FF0_0000_0000, 64'h0000_0010_0000_0000, 1'b0));
    apply(64'h0000_0FFF_FFFF_FFFF, 64'h0, 1'b1);
    chk("R3 upper slice with incoming carry", {cout, sum}, {1'b0, 64'h0000_1000_0000_0000});

    // R7: full-width propagate cases
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1);
    chk("R7 all-ones plus cin", {cout, sum}, {1'b1, 64'h0});
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    chk("R7 all-ones plus all-ones plus cin", {cout, sum}, {1'b1, 64'hFFFF_FFFF_FFFF_FFFF});
    chk("R8 all-ones in equal-width variant", {cout_lin, sum_lin}, {1'b1, 64'hFFFF_FFFF_FFFF_FFFF});

    // R4: carry out of top slice only from generate
    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1);
    chk("R4 top-slice generate", {cout, sum}, {1'b1, 64'h1});

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule